// File: doc/BRIEF.md
# Self-Clearing Trigger and Reset Control Bank

This block is a pair of 16-bit command registers on a simple synchronous microprocessor bus. Software writes 1 to an action bit and the block produces a timed output for it. The bit then clears itself with no further write. The outputs are:

- a one-shot request to corrupt a single bit in an upcoming frame;
- a performance-monitor reset pulse that is held for a guaranteed minimum time;
- a chip-wide soft reset;
- separate reset pulses for a pattern generator, a jitter attenuator and a framer.

While an action is still running, its bit reads back as 1. Writing 0 to a bit, or writing to a reserved bit, does nothing. The bus has only plain control pins. There is no streaming data path and no back-pressure, so no valid/ready handshake is needed. The only handshake is between the error request and the framer's acknowledge.

The chip-wide soft reset acts on this bank in the same way as a hardware reset. In the cycle it starts, every other pending action and running pulse is dropped, and all bus writes are ignored until it ends. Each sub-block reset reaches only its own output. The performance-monitor pulse width comes from parameters: the clock period in picoseconds and the minimum width. The pulse lasts the smallest whole number of cycles that covers that width, which is 25 cycles at 4 ns.

Top module: `ctl_trigger_bank`

## Requirements
- R1: After hardware reset every output is 0, and reads of both registers return 0x0000.
- R2: The global register is at address 0xD. Bit 9 reads the error-request pending state, bit 8 the monitor-pulse state and bit 0 the chip-reset state. The block register is at 0xE. Bit 7 reads the pattern-generator reset, bit 6 the jitter-attenuator reset and bit 5 the framer reset. A read is a cycle with cs=1 and we=0. Its data appears on `bus_rdata` in the following cycle, and `bus_rdata` is 0 after any cycle that is not a read.
- R3: Reserved bits read 0. These are global bits 15:10 and 7:1, and block bits 15:8 and 4:0. Reads of any other address return 0. Writes to reserved bits or other addresses have no effect.
- R4: Writing 1 to global bit 8 raises `pm_reset` from the next cycle for exactly PULSE_CYCLES = ceil(MIN_PULSE_PS/CLK_PERIOD_PS) cycles, and bit 8 reads 1 for that time. Writing 1 again while the pulse runs restarts the count.
- R5: Writing 1 to global bit 9 while no request is pending raises `err_ins_strobe` for exactly one cycle, the cycle after the write. Bit 9 then reads 1 until a cycle with `err_ins_ack`=1. A write made while a request is pending produces no new strobe.
- R6: Writing 1 to block bit 7, 6 or 5 raises that block's reset output from the next cycle for exactly BLK_RST_CYCLES cycles, and the bit reads 1 meanwhile. The other block outputs are not affected, and writing 1 again restarts the count.
- R7: Writing 1 to global bit 0 raises `chip_reset` for exactly CHIP_RST_CYCLES cycles, and bit 0 reads 1 meanwhile. At the same edge, all other outputs, pending requests and running pulses are cleared, including any other action requested in the same write.
- R8: While `chip_reset` is high, every bus write is ignored.
- R9: Writing 0 to an action bit that is running neither stops nor changes that action.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| bus_cs | input | 1 | Bus chip select |
| bus_we | input | 1 | Write enable (1 = write, 0 = read) |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the read |
| err_ins_ack | input | 1 | Framer acknowledge of the error request |
| err_ins_strobe | output | 1 | One-cycle bit-error insertion request |
| pm_reset | output | 1 | Stretched performance-monitor reset |
| chip_reset | output | 1 | Chip-wide soft reset |
| pattern_gen_rst | output | 1 | Pattern generator reset |
| jitter_rst | output | 1 | Jitter attenuator reset |
| framer_rst | output | 1 | Framer reset |

## Verification
The hardest situations to reach are collisions between actions. Examples are a chip reset that cuts a running monitor pulse short, an acknowledge that arrives in the same cycle as a repeated error write, and a restart written in the last cycle of a pulse. Directed sequences set up each of these collisions in an exact cycle. A long random phase then mixes writes, reads, acknowledges and rare chip resets. A behavioural model in the bench tracks counters and the pending flag, and it predicts every output and every read value on each clock.

// File: rtl/ctl_trig_pkg.sv
package ctl_trig_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_GLOBAL = 4'hD;
  localparam logic [ADDR_W-1:0] ADDR_BLOCK  = 4'hE;

  // global register bit positions
  localparam int GB_CHIP = 0;
  localparam int GB_PM   = 8;
  localparam int GB_ERR  = 9;

  // block register: lowest of three consecutive reset bits (framer, jitter, pattern)
  localparam int BB_LO   = 5;
  localparam int N_BLK   = 3;

  function automatic int cycles_for(input int width_ps, input int period_ps);
    return (width_ps + period_ps - 1) / period_ps;
  endfunction
endpackage

// File: rtl/ctl_pulse_timer.sv
module ctl_pulse_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (load)           cnt <= CW'(CYCLES);
    else if (cnt != '0)      cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/ctl_err_request.sv
module ctl_err_request (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic req,
  input  logic ack,
  output logic pending,
  output logic strobe
);
  logic accept;
  assign accept = req && !pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      strobe  <= 1'b0;
    end else if (clr) begin
      pending <= 1'b0;
      strobe  <= 1'b0;
    end else begin
      strobe <= accept;
      if (accept)   pending <= 1'b1;
      else if (ack) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/ctl_bus_decode.sv
module ctl_bus_decode
  import ctl_trig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lock,
  input  logic              st_chip,
  input  logic              st_pm,
  input  logic              st_err,
  input  logic [N_BLK-1:0]  st_blk,
  output logic              wr_global,
  output logic              wr_block,
  output logic [DATA_W-1:0] rdata
);
  logic              rd;
  logic [DATA_W-1:0] glob_view, blk_view, sel_view;

  assign wr_global = cs && we && !lock && (addr == ADDR_GLOBAL);
  assign wr_block  = cs && we && !lock && (addr == ADDR_BLOCK);
  assign rd        = cs && !we;

  always_comb begin
    glob_view          = '0;
    glob_view[GB_CHIP] = st_chip;
    glob_view[GB_PM]   = st_pm;
    glob_view[GB_ERR]  = st_err;
    blk_view           = '0;
    blk_view[BB_LO +: N_BLK] = st_blk;
    case (addr)
      ADDR_GLOBAL: sel_view = glob_view;
      ADDR_BLOCK:  sel_view = blk_view;
      default:     sel_view = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd ? sel_view : '0;
  end
endmodule

// File: rtl/ctl_trigger_bank.sv
module ctl_trigger_bank
  import ctl_trig_pkg::*;
#(
  parameter int CLK_PERIOD_PS   = 4000,
  parameter int MIN_PULSE_PS    = 100000,
  parameter int BLK_RST_CYCLES  = 4,
  parameter int CHIP_RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_cs,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        err_ins_ack,
  output logic        err_ins_strobe,
  output logic        pm_reset,
  output logic        chip_reset,
  output logic        pattern_gen_rst,
  output logic        jitter_rst,
  output logic        framer_rst
);
  localparam int PULSE_CYCLES = cycles_for(MIN_PULSE_PS, CLK_PERIOD_PS);

  logic             wr_global, wr_block;
  logic             chip_busy, chip_start, bank_clr;
  logic             pm_busy, err_pending;
  logic [N_BLK-1:0] blk_busy;

  ctl_bus_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (bus_cs),
    .we        (bus_we),
    .addr      (bus_addr),
    .lock      (chip_busy),
    .st_chip   (chip_busy),
    .st_pm     (pm_busy),
    .st_err    (err_pending),
    .st_blk    (blk_busy),
    .wr_global (wr_global),
    .wr_block  (wr_block),
    .rdata     (bus_rdata)
  );

  // chip-wide soft reset: its start and its whole duration clear the bank
  assign chip_start = wr_global && bus_wdata[GB_CHIP];
  assign bank_clr   = chip_start || chip_busy;

  ctl_pulse_timer #(.CYCLES(CHIP_RST_CYCLES)) u_chip_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (1'b0),
    .load  (chip_start),
    .busy  (chip_busy)
  );

  ctl_pulse_timer #(.CYCLES(PULSE_CYCLES)) u_pm_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (bank_clr),
    .load  (wr_global && bus_wdata[GB_PM]),
    .busy  (pm_busy)
  );

  ctl_err_request u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (bank_clr),
    .req     (wr_global && bus_wdata[GB_ERR]),
    .ack     (err_ins_ack),
    .pending (err_pending),
    .strobe  (err_ins_strobe)
  );

  for (genvar g = 0; g < N_BLK; g++) begin : g_blk
    ctl_pulse_timer #(.CYCLES(BLK_RST_CYCLES)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (bank_clr),
      .load  (wr_block && bus_wdata[BB_LO + g]),
      .busy  (blk_busy[g])
    );
  end

  assign pm_reset        = pm_busy;
  assign chip_reset      = chip_busy;
  assign framer_rst      = blk_busy[0];
  assign jitter_rst      = blk_busy[1];
  assign pattern_gen_rst = blk_busy[2];
endmodule

// File: rtl/ctl_trigger_bank_chk.sv
module ctl_trigger_bank_chk #(
  parameter int PULSE_CYCLES = 25
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_cs,
  input logic        bus_we,
  input logic [3:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic [15:0] bus_rdata,
  input logic        err_ins_strobe,
  input logic        pm_reset,
  input logic        chip_reset,
  input logic        pattern_gen_rst,
  input logic        jitter_rst,
  input logic        framer_rst
);
  int hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_cnt <= 0;
    else if (pm_reset) hi_cnt <= hi_cnt + 1;
    else               hi_cnt <= 0;
  end

  p_pm_min_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pm_reset) && !chip_reset) |-> (hi_cnt >= PULSE_CYCLES));

  p_pm_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && bus_we && bus_addr == 4'hD && bus_wdata[8] && !bus_wdata[0] && !chip_reset)
      |=> pm_reset);

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_ins_strobe |=> !err_ins_strobe);

  p_chip_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chip_reset |-> !(pm_reset || err_ins_strobe || pattern_gen_rst || jitter_rst || framer_rst));

  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && !bus_we && bus_addr != 4'hD && bus_addr != 4'hE) |=> (bus_rdata == 16'h0000));

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & 16'hFC1E) == 16'h0000);

  p_idle_rdata_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_cs && !bus_we) |=> (bus_rdata == 16'h0000));
endmodule

bind ctl_trigger_bank ctl_trigger_bank_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .bus_cs          (bus_cs),
  .bus_we          (bus_we),
  .bus_addr        (bus_addr),
  .bus_wdata       (bus_wdata),
  .bus_rdata       (bus_rdata),
  .err_ins_strobe  (err_ins_strobe),
  .pm_reset        (pm_reset),
  .chip_reset      (chip_reset),
  .pattern_gen_rst (pattern_gen_rst),
  .jitter_rst      (jitter_rst),
  .framer_rst      (framer_rst)
);

// File: tb/test_ctl_trigger_bank.sv
`timescale 1ns/1ps
module test_ctl_trigger_bank;
  localparam int PULSE = 25;   // ceil(100 ns / 4 ns)
  localparam int BLKN  = 4;
  localparam int CHIPN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cs = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        err_ins_ack = 1'b0;
  logic        err_ins_strobe, pm_reset, chip_reset;
  logic        pattern_gen_rst, jitter_rst, framer_rst;

  always #2 clk = ~clk;

  ctl_trigger_bank i_ctl_trigger_bank (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .err_ins_ack(err_ins_ack), .err_ins_strobe(err_ins_strobe),
    .pm_reset(pm_reset), .chip_reset(chip_reset),
    .pattern_gen_rst(pattern_gen_rst), .jitter_rst(jitter_rst),
    .framer_rst(framer_rst)
  );

  // ---------------- reference model ----------------
  int    m_pm, m_chip;
  int    m_blk[3];          // 0 framer, 1 jitter, 2 pattern
  bit    m_pend, m_strobe;
  logic [15:0] m_rdata;
  int    checks = 0, errors = 0;
  string tag = "R1";

  function automatic logic [15:0] view(input logic [3:0] a);
    logic [15:0] v = '0;
    if (a == 4'hD) begin
      v[0] = (m_chip > 0); v[8] = (m_pm > 0); v[9] = m_pend;
    end else if (a == 4'hE) begin
      v[5] = (m_blk[0] > 0); v[6] = (m_blk[1] > 0); v[7] = (m_blk[2] > 0);
    end
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pm = 0; m_chip = 0; m_pend = 0; m_strobe = 0; m_rdata = '0;
      foreach (m_blk[i]) m_blk[i] = 0;
    end else begin
      bit wr, busy, start, wrd, wre;
      wr    = bus_cs && bus_we;
      busy  = (m_chip > 0);
      wrd   = wr && !busy && bus_addr == 4'hD;
      wre   = wr && !busy && bus_addr == 4'hE;
      start = wrd && bus_wdata[0];
      m_rdata = (bus_cs && !bus_we) ? view(bus_addr) : 16'h0;
      if (start || busy) begin
        m_chip = start ? CHIPN : m_chip - 1;
        m_pm = 0; m_pend = 0; m_strobe = 0;
        foreach (m_blk[i]) m_blk[i] = 0;
      end else begin
        if (wrd && bus_wdata[8]) m_pm = PULSE;
        else if (m_pm > 0)       m_pm--;
        if (wrd && bus_wdata[9] && !m_pend) begin
          m_pend = 1; m_strobe = 1;
        end else begin
          m_strobe = 0;
          if (err_ins_ack) m_pend = 0;
        end
        foreach (m_blk[i]) begin
          if (wre && bus_wdata[5+i]) m_blk[i] = BLKN;
          else if (m_blk[i] > 0)     m_blk[i]--;
        end
      end
    end
  end

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("rdata (R2)",            bus_rdata,              m_rdata);
    chk("pm_reset (R4)",         16'(pm_reset),          16'(m_pm > 0));
    chk("err_ins_strobe (R5)",   16'(err_ins_strobe),    16'(m_strobe));
    chk("chip_reset (R7)",       16'(chip_reset),        16'(m_chip > 0));
    chk("framer_rst (R6)",       16'(framer_rst),        16'(m_blk[0] > 0));
    chk("jitter_rst (R6)",       16'(jitter_rst),        16'(m_blk[1] > 0));
    chk("pattern_gen_rst (R6)",  16'(pattern_gen_rst),   16'(m_blk[2] > 0));
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n = 1);
    repeat (n) begin
      @(negedge clk);
      bus_cs = 0; bus_we = 0;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_cs = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk);
    bus_cs = 1; bus_we = 0; bus_addr = a;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(4'hD); rd(4'hE); idle(2);

    tag = "R4";
    wr(4'hD, 16'h0100); rd(4'hD); idle(10);
    rd(4'hD); idle(5);
    wr(4'hD, 16'h0100);                 // restart mid-pulse
    idle(PULSE - 2); rd(4'hD); rd(4'hD); rd(4'hD); idle(3);

    tag = "R5";
    wr(4'hD, 16'h0200); rd(4'hD); idle(3);
    wr(4'hD, 16'h0200);                 // while pending: no new strobe
    idle(2);
    @(negedge clk); err_ins_ack = 1;
    @(negedge clk); err_ins_ack = 0;
    rd(4'hD); idle(1);
    wr(4'hD, 16'h0200);                 // ack in the strobe cycle
    @(negedge clk); bus_cs = 0; err_ins_ack = 1;
    @(negedge clk); err_ins_ack = 0;
    rd(4'hD);
    wr(4'hD, 16'h0200); idle(1);
    wr(4'hD, 16'h0200); err_ins_ack = 1; // ack + rewrite same cycle
    @(negedge clk); bus_cs = 0; err_ins_ack = 0;
    rd(4'hD); idle(2);

    tag = "R6";
    wr(4'hE, 16'h0020); idle(1); wr(4'hE, 16'h0040); idle(1);
    wr(4'hE, 16'h0080); rd(4'hE); idle(6);
    wr(4'hE, 16'h00E0); idle(2); wr(4'hE, 16'h0040); rd(4'hE); idle(6);

    tag = "R9";
    wr(4'hD, 16'h0100); wr(4'hE, 16'h00E0);
    wr(4'hD, 16'h0000); wr(4'hE, 16'h0000); rd(4'hD); rd(4'hE);
    idle(PULSE);

    tag = "R3";
    wr(4'hD, 16'hFCFE); rd(4'hD);
    wr(4'hE, 16'hFF1F); rd(4'hE);
    wr(4'h3, 16'hFFFF); rd(4'h3); rd(4'hF); rd(4'h0); idle(2);

    tag = "R7";
    wr(4'hD, 16'h0300); wr(4'hE, 16'h00E0);
    wr(4'hD, 16'h0001); rd(4'hD); rd(4'hE); idle(4);
    wr(4'hD, 16'h0301);                 // chip plus others in one write
    idle(1);

    tag = "R8";
    wr(4'hD, 16'h0300); wr(4'hE, 16'h00E0); wr(4'hD, 16'h0001);
    rd(4'hD); idle(2); rd(4'hD); rd(4'hE); idle(2);

    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 9);
      logic [15:0] d = 16'($urandom);
      @(negedge clk);
      err_ins_ack = ($urandom_range(0, 3) == 0);
      bus_addr = ($urandom_range(0, 4) == 0) ? 4'($urandom) : (op[0] ? 4'hD : 4'hE);
      if (op < 4) begin
        bus_cs = 1; bus_we = 1;
        bus_wdata = ($urandom_range(0, 40) == 0) ? d : (d & 16'hFFFE);
      end else if (op < 7) begin
        bus_cs = 1; bus_we = 0;
      end else begin
        bus_cs = 0;
      end
    end
    @(negedge clk); bus_cs = 0; err_ins_ack = 0;
    idle(PULSE + 4);
    finish_run();
  end
endmodule